// File: doc/BRIEF.md
# Protection Information Tuple Generator

This block sits on the write path of a block-storage controller. For every logical block it takes one byte stream: first the data bytes, then the metadata bytes. The data bytes, and any metadata bytes that come before the protection tuple, are run through a guard CRC. The metadata is then sent out byte for byte. Ordinary metadata bytes pass through unchanged. The bytes that fall inside the tuple field are replaced by the guard, the command's application tag and the current reference tag, all in big-endian order.

A command is opened with a one-cycle `cmd_start` pulse. This pulse loads the guard format (16-bit or 64-bit), the tuple placement (first in the metadata or last), the protection type, the zero-fill flag, the application tag and the 64-bit starting reference tag. The reference tag is built from the command's high and low words. Blocks then stream back to back with no further setup. In zero-fill mode the data is taken to be all zeros. The guard becomes a fixed value and the reference tag follows a narrower advance rule. Block size and metadata size are parameters.

Top module: `pi_tuple_gen`

## Requirements
- R1: After reset, `out_valid` and `blk_done` are low and `in_ready` is high, because the block position starts at the first data byte.
- R2: In 16-bit format, the guard is a CRC with polynomial 0x8BB7, not reflected, initial value 0 and no final XOR. It covers the data bytes plus the metadata bytes that precede the tuple. The tuple is 8 bytes: guard (2), application tag (2), then the low 32 bits of the reference tag (4), each most significant byte first.
- R3: In 64-bit format, the guard is a reflected CRC with polynomial 0xAD93D23594C93659, initial value all ones and a final XOR with all ones, over the same bytes. The tuple is 16 bytes: guard (8), application tag (2), then the low 48 bits of the reference tag (6), each most significant byte first.
- R4: With `cmd_tuple_first`=1 the tuple occupies metadata bytes starting at offset 0, and no metadata byte enters the guard. With `cmd_tuple_first`=0 it starts at offset META_BYTES minus the tuple size.
- R5: Metadata bytes outside the tuple leave unchanged and in input order. Data bytes produce no output (`out_valid` stays low while they are taken).
- R6: With zero-fill off, the reference tag increases by one after each block for types 0, 1 and 2. It stays constant for type 3 (`cmd_ptype`=3).
- R7: With zero-fill on, the guard field is 0x6482D367EB22B64E in 64-bit format and 0 in 16-bit format, whatever the data bytes are. The reference tag advances only for types 1 and 2.
- R8: The starting reference tag is {`cmd_ref_hi`, `cmd_ref_lo`}, with the high word in bits 63:32.
- R9: A metadata byte is taken only when `out_ready` is high, and `in_ready` is low while a metadata byte is offered against a low `out_ready`. Data bytes are taken whatever `out_ready` is.
- R10: `blk_done` is high for exactly one cycle, the cycle after the handshake of the block's last tuple byte.
- R11: `cmd_start` returns the block position to the first data byte and restarts the guard, discarding a partly streamed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse loading the command fields |
| cmd_fmt64 | input | 1 | 1 selects the 64-bit guard format |
| cmd_tuple_first | input | 1 | 1 places the tuple at the start of the metadata |
| cmd_ptype | input | 2 | Protection type 0..3 |
| cmd_zero_fill | input | 1 | Blocks are known to be all zeros |
| cmd_apptag | input | 16 | Application tag written into every tuple |
| cmd_ref_lo | input | 32 | Low word of the starting reference tag |
| cmd_ref_hi | input | 32 | High word of the starting reference tag |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| in_byte | input | 8 | Data then metadata bytes of each block |
| out_valid | output | 1 | Metadata output byte valid |
| out_ready | input | 1 | Downstream accepts metadata byte |
| out_byte | output | 8 | Metadata byte with the tuple spliced in |
| blk_done | output | 1 | One-cycle pulse after a block's last tuple byte |

## Verification
The hardest case to reach is one where several rules apply to the same byte. The guard must already be final when the first tuple byte is offered, and that same byte may also be held back by `out_ready`. The tuple may sit at either end of the metadata, and the reference tag must still follow the type and zero-fill rules across several blocks. Directed tasks stream whole blocks through the ports in both formats and both placements. One task stalls every other byte, so that data bytes are taken while metadata bytes are held. A further task abandons a block halfway through the data and starts a new command, to check that nothing from the partial block reaches the next guard.

// File: rtl/pi_tuple_pkg.sv
package pi_tuple_pkg;

  typedef enum logic [1:0] {
    PT_TYPE0 = 2'd0,
    PT_TYPE1 = 2'd1,
    PT_TYPE2 = 2'd2,
    PT_TYPE3 = 2'd3
  } pi_type_e;

  typedef struct packed {
    logic        fmt64;
    logic        tuple_first;
    pi_type_e    ptype;
    logic        zero_fill;
    logic [15:0] apptag;
  } pi_cfg_t;

  localparam logic [15:0] GUARD16_POLY   = 16'h8BB7;
  localparam logic [63:0] GUARD64_REFLEC = 64'h9A6C9329AC4BC9B5;

  function automatic logic [15:0] guard16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      r = r[15] ? ((r << 1) ^ GUARD16_POLY) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [63:0] guard64_step(input logic [63:0] c, input logic [7:0] b);
    logic [63:0] r;
    r = c ^ {56'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ GUARD64_REFLEC) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pi_guard_crc.sv
module pi_guard_crc
  import pi_tuple_pkg::*;
(
  input  logic        clk,
  input  logic        srst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] g16,
  output logic [63:0] g64
);

  logic [15:0] c16_q, c16_d;
  logic [63:0] c64_q, c64_d;

  always_comb begin
    c16_d = c16_q;
    c64_d = c64_q;
    if (clr) begin
      c16_d = 16'h0000;
      c64_d = '1;
    end else if (upd) begin
      c16_d = guard16_step(c16_q, din);
      c64_d = guard64_step(c64_q, din);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      c16_q <= 16'h0000;
      c64_q <= '1;
    end else if (clr || upd) begin
      c16_q <= c16_d;
      c64_q <= c64_d;
    end
  end

  assign g16 = c16_q;
  assign g64 = c64_q ^ {64{1'b1}};

endmodule

// File: rtl/pi_blk_seq.sv
module pi_blk_seq #(
  parameter int BLK_BYTES  = 32,
  parameter int META_BYTES = 24
) (
  input  logic       clk,
  input  logic       srst_n,
  input  logic       restart,
  input  logic       accept,
  input  logic       fmt64,
  input  logic       tuple_first,
  output logic       in_meta,
  output logic       in_tuple,
  output logic       hash_en,
  output logic [3:0] tidx,
  output logic       last_byte,
  output logic       last_tuple
);

  localparam int TOTAL = BLK_BYTES + META_BYTES;
  localparam int CNT_W = $clog2(TOTAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    int pos;
    int moff;
    int tsz;
    int toff;
    pos        = int'(cnt_q);
    tsz        = fmt64 ? 16 : 8;
    toff       = tuple_first ? 0 : META_BYTES - tsz;
    moff       = pos - BLK_BYTES;
    in_meta    = (pos >= BLK_BYTES);
    in_tuple   = in_meta && (moff >= toff) && (moff < toff + tsz);
    hash_en    = !in_meta || (moff < toff);
    tidx       = 4'(moff - toff);
    last_byte  = (pos == TOTAL - 1);
    last_tuple = in_tuple && (moff == toff + tsz - 1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (accept) begin
      cnt_d = last_byte ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
    end else if (restart || accept) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pi_tuple_mux.sv
module pi_tuple_mux #(
  parameter logic [63:0] ZERO_GUARD64 = 64'h6482D367EB22B64E
) (
  input  logic        fmt64,
  input  logic        zero_fill,
  input  logic [15:0] g16,
  input  logic [63:0] g64,
  input  logic [15:0] apptag,
  input  logic [47:0] reftag,
  input  logic [3:0]  tidx,
  output logic [7:0]  tbyte
);

  logic [127:0] tvec;
  logic [15:0]  gd16;
  logic [63:0]  gd64;

  always_comb begin
    int top;
    gd16 = zero_fill ? 16'h0000 : g16;
    gd64 = zero_fill ? ZERO_GUARD64 : g64;
    if (fmt64) begin
      tvec = {gd64, apptag, reftag};
    end else begin
      tvec = {gd16, apptag, reftag[31:0], 64'h0};
    end
    top   = 127 - 8 * int'(tidx);
    tbyte = tvec[top -: 8];
  end

endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen
  import pi_tuple_pkg::*;
#(
  parameter int          BLK_BYTES    = 32,
  parameter int          META_BYTES   = 24,
  parameter logic [63:0] ZERO_GUARD64 = 64'h6482D367EB22B64E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_fmt64,
  input  logic        cmd_tuple_first,
  input  logic [1:0]  cmd_ptype,
  input  logic        cmd_zero_fill,
  input  logic [15:0] cmd_apptag,
  input  logic [31:0] cmd_ref_lo,
  input  logic [31:0] cmd_ref_hi,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        blk_done
);

  logic [1:0]  rst_sync_q;
  logic        srst_n;
  pi_cfg_t     cfg_q, cfg_d;
  logic [63:0] ref_q, ref_d;
  logic        done_q, done_d;
  logic        in_meta, in_tuple, hash_en, last_byte, last_tuple;
  logic [3:0]  tidx;
  logic        accept, adv;
  logic [15:0] g16;
  logic [63:0] g64;
  logic [7:0]  tbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign in_ready  = !in_meta || out_ready;
  assign accept    = in_valid && in_ready;
  assign out_valid = in_valid && in_meta;
  assign out_byte  = in_tuple ? tbyte : in_byte;
  assign blk_done  = done_q;

  pi_blk_seq #(.BLK_BYTES(BLK_BYTES), .META_BYTES(META_BYTES)) u_seq (
    .clk(clk), .srst_n(srst_n), .restart(cmd_start), .accept(accept),
    .fmt64(cfg_q.fmt64), .tuple_first(cfg_q.tuple_first),
    .in_meta(in_meta), .in_tuple(in_tuple), .hash_en(hash_en), .tidx(tidx),
    .last_byte(last_byte), .last_tuple(last_tuple)
  );

  pi_guard_crc u_crc (
    .clk(clk), .srst_n(srst_n),
    .clr(cmd_start || (accept && last_byte)),
    .upd(accept && hash_en),
    .din(in_byte), .g16(g16), .g64(g64)
  );

  pi_tuple_mux #(.ZERO_GUARD64(ZERO_GUARD64)) u_mux (
    .fmt64(cfg_q.fmt64), .zero_fill(cfg_q.zero_fill), .g16(g16), .g64(g64),
    .apptag(cfg_q.apptag), .reftag(ref_q[47:0]), .tidx(tidx), .tbyte(tbyte)
  );

  always_comb begin
    if (cfg_q.zero_fill) adv = (cfg_q.ptype == PT_TYPE1) || (cfg_q.ptype == PT_TYPE2);
    else                 adv = (cfg_q.ptype != PT_TYPE3);
  end

  always_comb begin
    cfg_d  = cfg_q;
    ref_d  = ref_q;
    done_d = accept && last_tuple;
    if (cmd_start) begin
      cfg_d.fmt64       = cmd_fmt64;
      cfg_d.tuple_first = cmd_tuple_first;
      cfg_d.ptype       = pi_type_e'(cmd_ptype);
      cfg_d.zero_fill   = cmd_zero_fill;
      cfg_d.apptag      = cmd_apptag;
      ref_d             = {cmd_ref_hi, cmd_ref_lo};
    end else if (accept && last_byte && adv) begin
      ref_d = ref_q + 64'd1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q  <= '0;
      ref_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (cmd_start || accept) begin
        cfg_q <= cfg_d;
        ref_q <= ref_d;
      end
    end
  end

endmodule

// File: rtl/pi_tuple_gen_chk.sv
module pi_tuple_gen_chk (
  input logic        clk,
  input logic        srst_n,
  input logic        cmd_start,
  input logic        accept,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        blk_done,
  input logic [1:0]  ptype,
  input logic [63:0] ref_q,
  input logic [15:0] g16
);

  p_backpressure_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!srst_n)
    blk_done |-> $past(out_valid && out_ready));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!srst_n)
    blk_done |=> !blk_done);

  p_ref_type3_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (ptype == 2'd3 && !cmd_start) |=> $stable(ref_q));

  p_guard_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (!accept && !cmd_start) |=> $stable(g16));

endmodule

bind pi_tuple_gen pi_tuple_gen_chk u_chk (
  .clk(clk), .srst_n(srst_n), .cmd_start(cmd_start), .accept(accept),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .blk_done(blk_done), .ptype(cfg_q.ptype), .ref_q(ref_q), .g16(g16)
);

// File: tb/pi_tuple_gen_test.sv
`timescale 1ns/1ps
module pi_tuple_gen_test;

  localparam int BLK   = 32;
  localparam int META  = 24;
  localparam int TOTAL = BLK + META;
  localparam logic [63:0] ZG64 = 64'h6482D367EB22B64E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, cmd_fmt64, cmd_tuple_first, cmd_zero_fill;
  logic [1:0]  cmd_ptype;
  logic [15:0] cmd_apptag;
  logic [31:0] cmd_ref_lo, cmd_ref_hi;
  logic        in_valid, in_ready, out_valid, out_ready, blk_done;
  logic [7:0]  in_byte, out_byte;

  int checks = 0;
  int failures = 0;

  bit          m_fmt64, m_first, m_zf;
  int          m_ptype;
  logic [15:0] m_app;
  logic [63:0] m_ref;

  always #10 clk = ~clk;

  pi_tuple_gen #(.BLK_BYTES(BLK), .META_BYTES(META)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_fmt64(cmd_fmt64),
    .cmd_tuple_first(cmd_tuple_first), .cmd_ptype(cmd_ptype),
    .cmd_zero_fill(cmd_zero_fill), .cmd_apptag(cmd_apptag),
    .cmd_ref_lo(cmd_ref_lo), .cmd_ref_hi(cmd_ref_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .blk_done(blk_done)
  );

  function automatic logic [15:0] m_crc16(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8BB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [63:0] m_crc64(input logic [63:0] c, input logic [7:0] b);
    logic [63:0] r = c ^ {56'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 64'h9A6C9329AC4BC9B5) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_cmd(input bit f64, input bit first, input int pt, input bit zf,
                           input logic [15:0] app, input logic [63:0] rf);
    @(negedge clk);
    cmd_start = 1; cmd_fmt64 = f64; cmd_tuple_first = first; cmd_ptype = 2'(pt);
    cmd_zero_fill = zf; cmd_apptag = app; cmd_ref_hi = rf[63:32]; cmd_ref_lo = rf[31:0];
    @(negedge clk);
    cmd_start = 0;
    m_fmt64 = f64; m_first = first; m_ptype = pt; m_zf = zf; m_app = app; m_ref = rf;
  endtask

  task automatic run_block(input string req, input int seed, input bit stall);
    logic [7:0]   dat [BLK];
    logic [7:0]   met [META];
    logic [7:0]   expm[META];
    logic [7:0]   got [META];
    logic [15:0]  c16;
    logic [63:0]  c64;
    logic [127:0] tv;
    int tsz, toff, done_cnt, done_at, pass_err, hs_err, mis, first_bad;
    bit adv;
    tsz  = m_fmt64 ? 16 : 8;
    toff = m_first ? 0 : META - tsz;
    c16 = 16'h0; c64 = '1;
    for (int i = 0; i < BLK; i++) begin
      dat[i] = 8'(seed * 7 + i * 13 + 1);
      c16 = m_crc16(c16, dat[i]); c64 = m_crc64(c64, dat[i]);
    end
    for (int j = 0; j < META; j++) begin
      met[j] = 8'(seed * 3 + j * 29 + 5);
      if (j < toff) begin c16 = m_crc16(c16, met[j]); c64 = m_crc64(c64, met[j]); end
    end
    if (m_zf) begin c16 = 16'h0; c64 = ZG64; end
    else c64 = c64 ^ {64{1'b1}};
    if (m_fmt64) tv = {c64, m_app, m_ref[47:0]};
    else         tv = {c16, m_app, m_ref[31:0], 64'h0};
    for (int j = 0; j < META; j++) begin
      if (j >= toff && j < toff + tsz) expm[j] = tv[127 - 8 * (j - toff) -: 8];
      else expm[j] = met[j];
    end
    done_cnt = 0; done_at = -1; pass_err = 0; hs_err = 0;
    @(negedge clk);
    for (int i = 0; i < TOTAL; i++) begin
      bit st;
      st = stall && (i % 2 == 1);
      in_valid = 1; in_byte = (i < BLK) ? dat[i] : met[i - BLK]; out_ready = !st;
      #1;
      if (st) begin
        if (i >= BLK) begin
          if (in_ready !== 1'b0) hs_err++;
          @(negedge clk); out_ready = 1; #1;
        end else if (in_ready !== 1'b1) hs_err++;
      end
      if (i < BLK) begin
        if (out_valid !== 1'b0) pass_err++;
      end else begin
        if (out_valid !== 1'b1) pass_err++;
        got[i - BLK] = out_byte;
      end
      @(posedge clk); @(negedge clk);
      if (blk_done === 1'b1) begin done_cnt++; done_at = i; end
    end
    in_valid = 0; out_ready = 1;
    mis = 0; first_bad = -1;
    for (int j = 0; j < META; j++)
      if (got[j] !== expm[j]) begin mis++; if (first_bad < 0) first_bad = j; end
    if (first_bad < 0) check(1, req, "metadata", 0, 0);
    else check(0, req, $sformatf("metadata byte %0d", first_bad), got[first_bad], expm[first_bad]);
    check(pass_err == 0, "R5", "data bytes silent / meta valid", pass_err, 0);
    check(done_cnt == 1 && done_at == BLK + toff + tsz - 1, "R10", "blk_done byte index",
          done_at, BLK + toff + tsz - 1);
    if (stall) check(hs_err == 0, "R9", "in_ready under stall", hs_err, 0);
    if (m_zf) adv = (m_ptype == 1 || m_ptype == 2);
    else      adv = (m_ptype != 3);
    if (adv) m_ref = m_ref + 64'd1;
  endtask

  task automatic t_reset_r1;
    #1;
    check(out_valid === 1'b0 && blk_done === 1'b0 && in_ready === 1'b1, "R1",
          "reset outputs {out_valid,blk_done,in_ready}", {out_valid, blk_done, in_ready}, 3'b001);
  endtask

  task automatic t_models;
    logic [15:0] c16 = 16'h0;
    logic [63:0] c64 = '1;
    string s = "123456789";
    for (int i = 0; i < 9; i++) begin c16 = m_crc16(c16, s[i]); c64 = m_crc64(c64, s[i]); end
    check(c16 == 16'hD0DB, "R2", "16-bit model check value", c16, 16'hD0DB);
    check((c64 ^ {64{1'b1}}) == 64'hAE8B14860A799888, "R3", "64-bit model check value",
          c64 ^ {64{1'b1}}, 64'hAE8B14860A799888);
  endtask

  task automatic t_g16_last;
    start_cmd(0, 0, 1, 0, 16'hA55A, 64'h0000_0000_1234_5678);
    run_block("R2 R8 g16 last blk0", 1, 0);
    run_block("R6 g16 last blk1", 2, 0);
  endtask

  task automatic t_g64_last;
    start_cmd(1, 0, 2, 0, 16'h0F1E, 64'h0000_ABCD_0000_FFFF);
    run_block("R3 R8 g64 last blk0", 3, 0);
    run_block("R6 g64 last blk1 carry", 4, 0);
  endtask

  task automatic t_first;
    start_cmd(1, 1, 1, 0, 16'h7777, 64'h0000_0001_0000_0010);
    run_block("R4 g64 first", 5, 0);
    start_cmd(0, 1, 3, 0, 16'h1234, 64'h0000_0000_CAFE_0001);
    run_block("R4 g16 first type3 blk0", 6, 0);
    run_block("R6 type3 held blk1", 7, 0);
  endtask

  task automatic t_zero_fill;
    start_cmd(1, 0, 0, 1, 16'hBEEF, 64'h0000_0000_0000_0042);
    run_block("R7 zero g64 type0 blk0", 8, 0);
    run_block("R7 zero g64 type0 ref held", 9, 0);
    start_cmd(0, 0, 1, 1, 16'hFACE, 64'h0000_0000_0000_0100);
    run_block("R7 zero g16 blk0", 10, 0);
    run_block("R7 zero g16 type1 ref adv", 11, 0);
  endtask

  task automatic t_stall;
    start_cmd(0, 0, 2, 0, 16'h3C3C, 64'h0000_0000_8000_0000);
    run_block("R9 g16 stalled", 12, 1);
    start_cmd(1, 1, 1, 0, 16'hC3C3, 64'h0000_7FFF_FFFF_FFFE);
    run_block("R9 g64 stalled", 13, 1);
  endtask

  task automatic t_restart_r11;
    start_cmd(1, 0, 1, 0, 16'h1111, 64'h5);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      in_valid = 1; in_byte = 8'(8'hE0 + i);
      @(negedge clk);
    end
    in_valid = 0;
    #1;
    check(out_valid === 1'b0, "R11", "no output mid data", out_valid, 0);
    start_cmd(1, 0, 1, 0, 16'h2222, 64'h9);
    run_block("R11 after restart", 14, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_start = 0; cmd_fmt64 = 0; cmd_tuple_first = 0; cmd_ptype = 0;
    cmd_zero_fill = 0; cmd_apptag = 0; cmd_ref_lo = 0; cmd_ref_hi = 0;
    in_valid = 0; in_byte = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_models();
    t_g16_last();
    t_g64_last();
    t_first();
    t_zero_fill();
    t_stall();
    t_restart_r11();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule